// File: doc/BRIEF.md
# Coincident-Decoded Word Memory

This block is a synchronous read/write store of 1024 words, each 16 bits wide. It does not pick a word with one flat 10-to-1024 decoder. The address is split into a row field and a column field. Each field feeds its own small one-hot decoder. A storage word responds only where its row line and its column line are both high. This two-dimensional scheme replaces 1024 wide gates with two banks of 32 narrow ones and a grid of two-input ANDs.

A controller drives a memory-enable and a single direction bit, `rd_nwr`, which is 1 for read and 0 for write. The address and write data are set up before the clock edge on which the write takes place. Read data appears on a registered output one cycle after the read is issued. When the memory is not enabled, no word is selected, the stored contents stay as they are, and the output keeps its last value.

The decoder line vectors are brought out as observation ports, so that the selection grid can be watched directly.

The operation decode has three named modes:
- **OP_IDLE**: the enable is low.
- **OP_WRITE**: the enable is high and `rd_nwr` is 0.
- **OP_READ**: the enable is high and `rd_nwr` is 1.

Each clock moves between these modes according to the inputs alone. Any mode can follow any other.

Top module: `coincident_word_ram`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `rdata` is 0.
- R2: The row field is `addr[9:5]` and the column field is `addr[4:0]`. When enabled, `row_lines` has only the bit at the row index set, and `col_lines` has only the bit at the column index set. For example, address 404 sets `row_lines[12]` and `col_lines[20]`.
- R3: While `mem_en` is 1, exactly one bit of `row_lines` and exactly one bit of `col_lines` are 1.
- R4: While `mem_en` is 0, `row_lines` and `col_lines` are all zeros.
- R5: With `mem_en`=1 and `rd_nwr`=0, `wdata` is stored at `addr` on the rising clock edge, and `rdata` does not change on that edge.
- R6: With `mem_en`=1 and `rd_nwr`=1, `rdata` shows the word stored at `addr` after the next rising clock edge.
- R7: With `mem_en`=0, no stored word changes, whatever `rd_nwr`, `addr` and `wdata` are, and `rdata` holds its value.
- R8: A write changes only the word at the row and column intersection. Words that share only its row, or only its column, keep their contents.
- R9: A read issued on the cycle right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| mem_en | input | 1 | Memory enable; 0 means no word is selected |
| rd_nwr | input | 1 | Direction: 1 read, 0 write |
| addr | input | 10 | Word address: row field in bits 9..5, column field in bits 4..0 |
| wdata | input | 16 | Data to be stored |
| rdata | output | 16 | Registered read data |
| row_lines | output | 32 | One-hot row decoder lines |
| col_lines | output | 32 | One-hot column decoder lines |

## Verification
The properties check these on every cycle:
- Both decoders are one-hot while the memory is enabled and all zeros while it is idle.
- At most one word of the grid is selected at a time.
- The output register does not move during writes or idle cycles.

Only the scenarios can show whether the correct word was stored and returned. For that, a flat behavioural array is compared against `rdata` after every edge, while the bench:
- fills the whole memory;
- writes next to a target word along its row and its column;
- reads right after a write;
- drives idle cycles that carry write-like data.

// File: rtl/cdm_pkg.sv
package cdm_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } cdm_op_e;
endpackage

// File: rtl/cdm_onehot_dec.sv
module cdm_onehot_dec #(
    parameter  int IN_W  = 5,
    localparam int OUT_N = 1 << IN_W
) (
    input  logic             en,
    input  logic [IN_W-1:0]  code,
    output logic [OUT_N-1:0] lines
);
    for (genvar g = 0; g < OUT_N; g++) begin : g_line
        assign lines[g] = en && (code == IN_W'(g));
    end
endmodule

// File: rtl/cdm_cell_array.sv
module cdm_cell_array #(
    parameter  int ROWS   = 32,
    parameter  int COLS   = 32,
    parameter  int DATA_W = 16,
    localparam int WORDS  = ROWS * COLS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ROWS-1:0]   row_lines,
    input  logic [COLS-1:0]   col_lines,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_q
);
    logic [DATA_W-1:0] cells [WORDS];
    logic [WORDS-1:0]  word_sel;
    logic [DATA_W-1:0] rd_mux;

    // Coincidence grid: a word is enabled only where both of its lines are high.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign word_sel[r*COLS + c] = row_lines[r] & col_lines[c];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (wr_en && word_sel[i]) begin
                cells[i] <= wdata;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (word_sel[i]) begin
                rd_mux = rd_mux | cells[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= rd_mux;
        end
    end

    // R8
    single_word_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(word_sel));
endmodule

// File: rtl/coincident_word_ram.sv
module coincident_word_ram #(
    parameter  int ADDR_W = 10,
    parameter  int DATA_W = 16,
    localparam int COL_W  = ADDR_W / 2,
    localparam int ROW_W  = ADDR_W - COL_W,
    localparam int ROWS   = 1 << ROW_W,
    localparam int COLS   = 1 << COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_en,
    input  logic              rd_nwr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [ROWS-1:0]   row_lines,
    output logic [COLS-1:0]   col_lines
);
    import cdm_pkg::*;

    cdm_op_e op;
    logic    dec_en;
    logic    wr_en;
    logic    rd_en;

    always_comb begin
        unique case ({mem_en, rd_nwr})
            2'b10:   op = OP_WRITE;
            2'b11:   op = OP_READ;
            default: op = OP_IDLE;
        endcase
    end

    assign dec_en = (op != OP_IDLE);
    assign wr_en  = (op == OP_WRITE);
    assign rd_en  = (op == OP_READ);

    cdm_onehot_dec #(.IN_W(ROW_W)) u_row_dec (
        .en    (dec_en),
        .code  (addr[ADDR_W-1:COL_W]),
        .lines (row_lines)
    );

    cdm_onehot_dec #(.IN_W(COL_W)) u_col_dec (
        .en    (dec_en),
        .code  (addr[COL_W-1:0]),
        .lines (col_lines)
    );

    cdm_cell_array #(
        .ROWS   (ROWS),
        .COLS   (COLS),
        .DATA_W (DATA_W)
    ) u_cells (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .row_lines (row_lines),
        .col_lines (col_lines),
        .wdata     (wdata),
        .rdata_q   (rdata)
    );

    // R3
    lines_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> ($onehot(row_lines) && $onehot(col_lines)));

    // R4
    lines_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |-> (row_lines == '0 && col_lines == '0));

    // R5
    write_keeps_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !rd_nwr) |=> $stable(rdata));

    // R7
    idle_keeps_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |=> $stable(rdata));
endmodule

// File: tb/sim_coincident_word_ram.sv
module sim_coincident_word_ram;
    localparam int PERIOD = 10;
    localparam int WORDS  = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_en = 1'b0;
    logic        rd_nwr = 1'b1;
    logic [9:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [31:0] row_lines;
    logic [31:0] col_lines;

    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;
    logic [15:0] ref_mem [WORDS];
    logic [15:0] exp_out = '0;

    coincident_word_ram u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_en    (mem_en),
        .rd_nwr    (rd_nwr),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .row_lines (row_lines),
        .col_lines (col_lines)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock of stimulus; inputs change at the falling edge.
    task automatic step(input bit en, input bit rd, input logic [9:0] a, input logic [15:0] d,
                        input string tag);
        @(negedge clk);
        mem_en = en; rd_nwr = rd; addr = a; wdata = d;
        #1;
        if (en) begin
            check("R2 row", row_lines, 32'd1 << a[9:5]);
            check("R2 col", col_lines, 32'd1 << a[4:0]);
            check("R3 lines", {30'd0, $onehot(row_lines), $onehot(col_lines)}, 32'd3);
        end else begin
            check("R4 lines", row_lines | col_lines, 32'd0);
        end
        @(posedge clk);
        if (en && !rd) ref_mem[a] = d;
        if (en && rd)  exp_out = ref_mem[a];
        @(negedge clk);
        check(tag, {16'd0, rdata}, {16'd0, exp_out});
    endtask

    function automatic logic [15:0] pat(input int i);
        return 16'(i * 37) ^ 16'hA5C3;
    endfunction

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", {16'd0, rdata}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 after reset", {16'd0, rdata}, 32'd0);

        // R5: fill every word; output must hold throughout
        for (int i = 0; i < WORDS; i++) step(1, 0, 10'(i), pat(i), "R5 write hold");
        // R6: read all words back
        for (int i = 0; i < WORDS; i++) step(1, 1, 10'(i), 16'h0, "R6 read");

        // R2: address 404 maps to row 12, column 20
        step(1, 1, 10'd404, 16'h0, "R6 read 404");
        check("R2 404 row", row_lines, 32'd1 << 12);
        check("R2 404 col", col_lines, 32'd1 << 20);

        // R8: write the target, then read neighbours on its row and column
        step(1, 0, 10'd404, 16'hBEEF, "R5 write 404");
        step(1, 1, 10'd403, 16'h0, "R8 same row");
        step(1, 1, 10'd405, 16'h0, "R8 same row");
        step(1, 1, 10'd372, 16'h0, "R8 same col");
        step(1, 1, 10'd436, 16'h0, "R8 same col");
        step(1, 1, 10'd404, 16'h0, "R8 target");

        // R9: read right after write to the same address
        step(1, 0, 10'd777, 16'h1234, "R5 write");
        step(1, 1, 10'd777, 16'h0, "R9 read after write");
        step(1, 0, 10'd0, 16'hFFFF, "R5 write");
        step(1, 1, 10'd0, 16'h0, "R9 read after write");

        // R7: idle cycles carrying write-like stimulus change nothing
        step(0, 0, 10'd777, 16'hDEAD, "R7 idle hold");
        step(0, 1, 10'd0, 16'h0BAD, "R7 idle hold");
        step(0, 0, 10'd1023, 16'h5555, "R7 idle hold");
        step(1, 1, 10'd777, 16'h0, "R7 word unchanged");
        step(1, 1, 10'd1023, 16'h0, "R7 word unchanged");

        // Mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int sel = int'($urandom_range(0, 3));
            step(sel != 0, sel >= 2, 10'($urandom_range(0, WORDS-1)), 16'($urandom),
                 "R6 mixed traffic");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule